// File: doc/BRIEF.md
# Processor status word register

This block holds the condition flags and the two control bits of a processor core in one register. After each ALU operation the core raises an update strobe and supplies the result, the raw carry-out, the signed-overflow indication and the class of the operation. The register then sets sign, zero, carry and overflow from those inputs, and sets an equal flag when the operation is a compare. The interrupt-enable and supervisor-mode bits sit in the same word. Only code running in supervisor mode can change them, through a privileged write port.

A trap request puts the core into supervisor mode with interrupts masked, whatever mode it was in before. The flags appear as separate outputs and as one packed word that software can read. The ALU and the interrupt controller lie outside this block.

Top module: `status_word_reg`

## Requirements
- R1: While reset is asserted, the register holds supervisor = 1 and interrupt enable = 0, and carry, zero, sign, overflow and equal are all 0.
- R2: The operation class is encoded 0 = add, 1 = subtract, 2 = compare, 3 = logic. An update of class add sets sign to the result MSB, sets zero when the result is all zeros, sets carry to the carry-out input and sets overflow to the overflow input.
- R3: An update of class subtract sets sign, zero and overflow as for add, and sets carry to the inverted carry-out input, so that carry reads as a borrow out of the top bit.
- R4: An update of class compare sets sign, zero, carry and overflow as for subtract. It also sets equal to 1 when the result is all zeros and to 0 otherwise.
- R5: An update of class logic sets sign and zero from the result and clears carry and overflow. An update of any class other than compare leaves equal unchanged.
- R6: When the update strobe, the write strobe and the trap request are all low, every bit of the status word keeps its value.
- R7: The packed word carries carry at bit 0, zero at bit 1, sign at bit 2, overflow at bit 3, equal at bit 4, interrupt enable at bit 5 and supervisor at bit 6. All higher bits read 0. Each separate flag output equals its bit in the word.
- R8: A privileged write made while supervisor = 1 loads bits 6..0 of the write data into the same bit positions on the next clock. In that cycle the write takes precedence over a flag update.
- R9: A privileged write made while supervisor = 0 is ignored, and all bits keep their values.
- R10: A trap request sets supervisor to 1 and interrupt enable to 0 on the next clock, even if a privileged write happens in the same cycle. It does not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Flag update strobe from the ALU |
| op_class | input | 2 | Class of the operation: 0 add, 1 subtract, 2 compare, 3 logic |
| alu_res | input | DATA_W | Result of the operation |
| alu_cout | input | 1 | Raw carry out of the adder's top bit |
| alu_ovf | input | 1 | Signed overflow of the operation |
| wr_en | input | 1 | Privileged write strobe |
| wr_data | input | WORD_W | Privileged write data |
| trap_req | input | 1 | Request to enter supervisor mode with interrupts masked |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| flag_e | output | 1 | Equal flag |
| int_en | output | 1 | Interrupt enable |
| sup_mode | output | 1 | Supervisor mode |
| psw_word | output | WORD_W | Packed status word |

## Verification
The bench builds the block with DATA_W = 4 and WORD_W = 8. At that width it can drive every result value with both carry and overflow values for all four operation classes, 256 updates in total. It also writes all 128 values of the seven control and flag bits through the privileged port. This covers every all-zero and MSB-set case, and every write that drops the core into user mode, after which the bench checks that a rejected write leaves the word unchanged. The bench also checks the same-cycle collisions between write and update and between trap and write.

// File: rtl/status_word_pkg.sv
package status_word_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_CMP   = 2'd2,
        OPC_LOGIC = 2'd3
    } op_class_e;

    // Packed from MSB to LSB so the struct maps onto word bits 6..0 (R7).
    typedef struct packed {
        logic sv;
        logic ie;
        logic e;
        logic v;
        logic s;
        logic z;
        logic c;
    } status_t;

    localparam int unsigned STATUS_BITS = $bits(status_t);

    localparam status_t STATUS_RESET = '{sv: 1'b1, ie: 1'b0, e: 1'b0,
                                         v: 1'b0, s: 1'b0, z: 1'b0, c: 1'b0};

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic e;
    } arith_flags_t;

endpackage

// File: rtl/status_flag_gen.sv
module status_flag_gen
    import status_word_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  op_class_e          op,
    input  logic [DATA_W-1:0]  res,
    input  logic               cout,
    input  logic               ovf,
    input  logic               e_cur,
    output arith_flags_t       flags
);
    localparam int unsigned MSB = DATA_W - 1;

    logic res_zero;
    assign res_zero = (res == '0);

    always_comb begin
        flags.s = res[MSB];
        flags.z = res_zero;
        flags.e = e_cur;
        unique case (op)
            OPC_ADD: begin
                flags.c = cout;
                flags.v = ovf;
            end
            OPC_SUB: begin
                flags.c = ~cout;
                flags.v = ovf;
            end
            OPC_CMP: begin
                flags.c = ~cout;
                flags.v = ovf;
                flags.e = res_zero;
            end
            default: begin
                flags.c = 1'b0;
                flags.v = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/status_priv_gate.sv
module status_priv_gate (
    input  logic sup_cur,
    input  logic wr_en,
    output logic wr_accept
);
    assign wr_accept = wr_en & sup_cur;
endmodule

// File: rtl/status_pack.sv
module status_pack
    import status_word_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  status_t            st,
    output logic [WORD_W-1:0]  word
);
    generate
        if (WORD_W > STATUS_BITS) begin : g_pad
            assign word = {{(WORD_W - STATUS_BITS){1'b0}}, st};
        end else begin : g_exact
            assign word = st[WORD_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
    import status_word_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [1:0]         op_class,
    input  logic [DATA_W-1:0]  alu_res,
    input  logic               alu_cout,
    input  logic               alu_ovf,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               trap_req,
    output logic               flag_c,
    output logic               flag_z,
    output logic               flag_s,
    output logic               flag_v,
    output logic               flag_e,
    output logic               int_en,
    output logic               sup_mode,
    output logic [WORD_W-1:0]  psw_word
);
    localparam int unsigned WR_BITS = STATUS_BITS;

    status_t      st_q;
    status_t      st_d;
    arith_flags_t gen_flags;
    logic         wr_accept;
    status_t      wr_val;
    op_class_e    op_e;

    assign op_e   = op_class_e'(op_class);
    assign wr_val = status_t'(wr_data[WR_BITS-1:0]);

    status_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .op    (op_e),
        .res   (alu_res),
        .cout  (alu_cout),
        .ovf   (alu_ovf),
        .e_cur (st_q.e),
        .flags (gen_flags)
    );

    status_priv_gate u_gate (
        .sup_cur   (st_q.sv),
        .wr_en     (wr_en),
        .wr_accept (wr_accept)
    );

    status_pack #(.WORD_W(WORD_W)) u_pack (
        .st   (st_q),
        .word (psw_word)
    );

    // Priority: trap > accepted write > flag update > hold.
    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.c = gen_flags.c;
            st_d.z = gen_flags.z;
            st_d.s = gen_flags.s;
            st_d.v = gen_flags.v;
            st_d.e = gen_flags.e;
        end
        if (wr_accept) begin
            st_d = wr_val;
        end
        if (trap_req) begin
            st_d.sv = 1'b1;
            st_d.ie = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STATUS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_c   = psw_word[0];
    assign flag_z   = psw_word[1];
    assign flag_s   = psw_word[2];
    assign flag_v   = psw_word[3];
    assign flag_e   = psw_word[4];
    assign int_en   = psw_word[5];
    assign sup_mode = psw_word[6];

    // R1: first sampled edge after reset shows the reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sup_mode && !int_en && !flag_c && !flag_z
                          && !flag_s && !flag_v && !flag_e));

    // R4: compare drives equal from the result
    p_cmp_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class == 2'd2 && !wr_en) |=> (flag_e == $past(alu_res == '0)));

    // R5: logic clears carry and overflow
    p_logic_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class == 2'd3 && !wr_en) |=> (!flag_c && !flag_v));

    // R5: non-compare classes leave equal alone
    p_equal_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class != 2'd2 && !wr_en) |=> $stable(flag_e));

    // R6: no request means no change
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_en && !trap_req) |=> $stable(psw_word));

    // R9: user-mode write is dropped
    p_user_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sup_mode && !upd_en && !trap_req) |=> $stable(psw_word));

    // R10: trap forces supervisor with interrupts masked
    p_trap_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (sup_mode && !int_en));

    // R7: upper bits stay zero
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_word >> WR_BITS) == '0);

endmodule

// File: tb/status_word_reg_test.sv
module status_word_reg_test;
    localparam int DW = 4;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_en = 1'b0;
    logic [1:0]    op_class = 2'd0;
    logic [DW-1:0] alu_res = '0;
    logic          alu_cout = 1'b0;
    logic          alu_ovf = 1'b0;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          trap_req = 1'b0;
    logic flag_c, flag_z, flag_s, flag_v, flag_e, int_en, sup_mode;
    logic [WW-1:0] psw_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic m_c = 0, m_z = 0, m_s = 0, m_v = 0, m_e = 0, m_ie = 0, m_sv = 1;

    always #4 clk = ~clk;

    status_word_reg #(.DATA_W(DW), .WORD_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
        .alu_res(alu_res), .alu_cout(alu_cout), .alu_ovf(alu_ovf),
        .wr_en(wr_en), .wr_data(wr_data), .trap_req(trap_req),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v),
        .flag_e(flag_e), .int_en(int_en), .sup_mode(sup_mode), .psw_word(psw_word)
    );

    function automatic logic [WW-1:0] model_word();
        return {1'b0, m_sv, m_ie, m_e, m_v, m_s, m_z, m_c};
    endfunction

    task automatic chk(input string rq, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic chk_word(input string rq);
        logic [WW-1:0] sep;
        chk(rq, psw_word, model_word());
        sep = {1'b0, sup_mode, int_en, flag_e, flag_v, flag_s, flag_z, flag_c};
        chk("R7 separate outputs", sep, psw_word);
    endtask

    task automatic idle_inputs();
        upd_en = 0; wr_en = 0; trap_req = 0;
    endtask

    task automatic model_update(input logic [1:0] op, input logic [DW-1:0] r,
                                input logic co, input logic ov);
        m_s = r[DW-1];
        m_z = (r == 0);
        case (op)
            2'd0: begin m_c = co;  m_v = ov; end
            2'd1: begin m_c = !co; m_v = ov; end
            2'd2: begin m_c = !co; m_v = ov; m_e = (r == 0); end
            default: begin m_c = 0; m_v = 0; end
        endcase
    endtask

    task automatic do_trap();
        idle_inputs(); trap_req = 1;
        m_sv = 1; m_ie = 0;
        @(negedge clk); idle_inputs();
        chk_word("R10 trap entry");
    endtask

    task automatic do_write(input logic [WW-1:0] v, input string rq);
        idle_inputs(); wr_en = 1; wr_data = v;
        if (m_sv) {m_sv, m_ie, m_e, m_v, m_s, m_z, m_c} = v[6:0];
        @(negedge clk); idle_inputs();
        chk_word(rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_word("R1 reset state held");
        chk("R1 reset word", psw_word, 8'h40);
        rst_n = 1;
        @(negedge clk);
        chk_word("R1 after release");

        // R2 R3 R4 R5: exhaustive update sweep
        for (int op = 0; op < 4; op++) begin
            for (int r = 0; r < 16; r++) begin
                for (int k = 0; k < 4; k++) begin
                    idle_inputs();
                    upd_en = 1; op_class = op[1:0]; alu_res = r[DW-1:0];
                    alu_cout = k[0]; alu_ovf = k[1];
                    model_update(op[1:0], r[DW-1:0], k[0], k[1]);
                    @(negedge clk); idle_inputs();
                    case (op)
                        0: chk_word("R2 add update");
                        1: chk_word("R3 subtract borrow");
                        2: chk_word("R4 compare equal");
                        default: chk_word("R5 logic update");
                    endcase
                end
            end
        end

        // R6: idle hold
        alu_res = 4'h0; op_class = 2'd2;
        @(negedge clk);
        chk_word("R6 idle hold");

        // R8 R9: write sweep over all seven bits
        for (int v = 0; v < 128; v++) begin
            do_write(v[WW-1:0], "R8 supervisor write");
            if (!v[6]) begin
                do_write(~v[WW-1:0], "R9 user write ignored");
                do_trap();
                chk("R10 flags kept on trap", {3'b0, psw_word[4:0]}, {3'b0, v[4:0]});
            end
        end

        // R8: write beats same-cycle update
        do_trap();
        idle_inputs(); wr_en = 1; wr_data = 8'h55; upd_en = 1; op_class = 2'd0;
        alu_res = 4'h0; alu_cout = 1;
        {m_sv, m_ie, m_e, m_v, m_s, m_z, m_c} = 7'h55;
        @(negedge clk); idle_inputs();
        chk_word("R8 write over update");

        // R9: user-mode write with an update in the same cycle still updates flags
        do_write(8'h20, "R8 drop to user");
        idle_inputs(); wr_en = 1; wr_data = 8'h7f; upd_en = 1; op_class = 2'd3;
        alu_res = 4'h8;
        model_update(2'd3, 4'h8, 1'b0, 1'b0);
        @(negedge clk); idle_inputs();
        chk_word("R9 user write rejected with update");

        // R10: trap beats same-cycle write
        idle_inputs(); trap_req = 1; wr_en = 1; wr_data = 8'h3f;
        m_sv = 1; m_ie = 0;
        @(negedge clk); idle_inputs();
        chk_word("R10 trap from user with write");
        idle_inputs(); trap_req = 1; wr_en = 1; wr_data = 8'h3f;
        {m_sv, m_ie, m_e, m_v, m_s, m_z, m_c} = 7'h3f;
        m_sv = 1; m_ie = 0;
        @(negedge clk); idle_inputs();
        chk_word("R10 trap over supervisor write");

        // R1: reset mid-run
        rst_n = 0;
        m_c = 0; m_z = 0; m_s = 0; m_v = 0; m_e = 0; m_ie = 0; m_sv = 1;
        @(negedge clk);
        chk_word("R1 reset mid-run");
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule